// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the general-purpose registers of a 32-bit processor core that runs in seven operating modes. Instructions always name one of sixteen architectural registers, R0 to R15. Behind these names sit 31 physical 32-bit registers. The current mode decides which physical copy each name refers to. The fast-interrupt mode has its own private R8 to R14. Each of the other four exception modes has its own stack pointer (R13) and link register (R14). User and system modes use the common set. R15 is the program counter and exists only once.

The datapath reads two operands through combinational ports and writes one result per clock, always through the current mode's view of the registers. A second write path serves the exception controller. It deposits a return address into R14 of the mode being entered, whatever mode is current. The program counter is always visible on its own output.

Top module: `bank_rf_top`

## Requirements
- R1: While reset is asserted, and after it, until the first write, every architectural register reads zero in every mode.
- R2: Mode codes are 5 bits wide: user 10000, fast interrupt 10001, interrupt 10010, supervisor 10011, abort 10111, undefined 11011, system 11111. System mode and any code not in this list use exactly the user-mode registers.
- R3: In fast-interrupt mode, R8 to R14 refer to seven private registers, and R0 to R7 are shared with user mode.
- R4: The interrupt, supervisor, abort and undefined modes each have a private R13 and R14. Their R0 to R12 are shared with user mode.
- R5: R15 is one register shared by all modes, and the program-counter output always shows its value.
- R6: Both read ports return the addressed register combinationally. A read of a register that is being written in the same cycle returns the old value.
- R7: When the write enable is high, the register that the write index names in the current mode takes the write data at the clock edge. No other register changes.
- R8: When the link-write enable is high, R14 of the mode given on the link-mode input takes the link data at the clock edge, whatever the current mode. An unlisted code there selects the user-mode R14.
- R9: When both write paths target the same physical register in one cycle, the link-write data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 5 | Current operating mode code |
| rd_a_idx | input | 4 | Architectural index, read port A |
| rd_a_data | output | 32 | Read data, port A |
| rd_b_idx | input | 4 | Architectural index, read port B |
| rd_b_data | output | 32 | Read data, port B |
| wr_en | input | 1 | Datapath write enable |
| wr_idx | input | 4 | Datapath write index (current mode) |
| wr_data | input | 32 | Datapath write data |
| lnk_en | input | 1 | Exception link-register write enable |
| lnk_mode | input | 5 | Mode whose R14 the link write targets |
| lnk_data | input | 32 | Link write data |
| pc_o | output | 32 | Current program counter (R15) |

## Verification
Some properties are checked by assertions on every cycle. R15 resolves to the single shared register in every mode, and read port A always agrees with the program-counter output for R15. Low indices never leave the shared set. The fast-interrupt high registers always resolve into their own private range. A write becomes visible on the next cycle when the mode and index are unchanged. The program counter holds steady when nothing writes. Other behaviours need a sequence of stimulus, so only the bench scenarios can show them. These are the separation of banked copies between modes, the link path reaching a mode other than the current one, and the priority when both writes collide. The bench's reference model tracks each mode's view and compares the outputs on every clock.

// File: rtl/bank_rf_pkg.sv
package bank_rf_pkg;

  localparam int MODE_W = 5;
  localparam int ARCH_W = 4;
  localparam int PHYS_N = 31;
  localparam int PHYS_W = $clog2(PHYS_N);
  localparam int FIQ_LO = 8;
  localparam int SP_IDX = 13;
  localparam int LR_IDX = 14;
  localparam int PC_IDX = 15;
  localparam int FIQ_BASE = 16;
  localparam int EXC_BASE = FIQ_BASE + (LR_IDX - FIQ_LO + 1);

  typedef enum logic [MODE_W-1:0] {
    MD_USR = 5'b10000,
    MD_FIQ = 5'b10001,
    MD_IRQ = 5'b10010,
    MD_SVC = 5'b10011,
    MD_ABT = 5'b10111,
    MD_UND = 5'b11011,
    MD_SYS = 5'b11111
  } mode_e;

  typedef enum logic [2:0] {
    BK_COMMON = 3'd0,
    BK_FAST   = 3'd1,
    BK_IRQ    = 3'd2,
    BK_SVC    = 3'd3,
    BK_ABT    = 3'd4,
    BK_UND    = 3'd5
  } bank_e;

  function automatic bank_e bank_of(input logic [MODE_W-1:0] m);
    case (m)
      MD_FIQ:  return BK_FAST;
      MD_IRQ:  return BK_IRQ;
      MD_SVC:  return BK_SVC;
      MD_ABT:  return BK_ABT;
      MD_UND:  return BK_UND;
      default: return BK_COMMON;
    endcase
  endfunction

  function automatic logic [PHYS_W-1:0] phys_of(input bank_e b,
                                                input logic [ARCH_W-1:0] idx);
    int i;
    int slot;
    i = int'(idx);
    if (i == PC_IDX) return PHYS_W'(PC_IDX);
    if (b == BK_FAST && i >= FIQ_LO) return PHYS_W'(FIQ_BASE + i - FIQ_LO);
    if (b != BK_COMMON && b != BK_FAST && i >= SP_IDX) begin
      slot = int'(b) - int'(BK_IRQ);
      return PHYS_W'(EXC_BASE + 2 * slot + (i - SP_IDX));
    end
    return PHYS_W'(i);
  endfunction

endpackage

// File: rtl/bank_rf_decode.sv
module bank_rf_decode
  import bank_rf_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [ARCH_W-1:0] idx,
  output logic [PHYS_W-1:0] phys
);
  bank_e bank;
  always_comb begin
    bank = bank_of(mode);
    phys = phys_of(bank, idx);
  end
endmodule

// File: rtl/bank_rf_store.sv
module bank_rf_store
  import bank_rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_a,
  input  logic [PHYS_W-1:0] wa_phys,
  input  logic [DATA_W-1:0] wa_data,
  input  logic              we_l,
  input  logic [PHYS_W-1:0] wl_phys,
  input  logic [DATA_W-1:0] wl_data,
  input  logic [PHYS_W-1:0] ra_phys,
  output logic [DATA_W-1:0] ra_data,
  input  logic [PHYS_W-1:0] rb_phys,
  output logic [DATA_W-1:0] rb_data,
  output logic [DATA_W-1:0] pc_data
);
  logic [DATA_W-1:0] cells [PHYS_N];

  for (genvar k = 0; k < PHYS_N; k++) begin : g_cell
    logic [DATA_W-1:0] q;
    logic hit_a;
    logic hit_l;
    assign hit_a = we_a && (wa_phys == PHYS_W'(k));
    assign hit_l = we_l && (wl_phys == PHYS_W'(k));
    always_ff @(posedge clk) begin
      if (!rst_n)     q <= '0;
      else if (hit_l) q <= wl_data;
      else if (hit_a) q <= wa_data;
    end
    assign cells[k] = q;
  end

  always_comb begin
    ra_data = '0;
    rb_data = '0;
    if (int'(ra_phys) < PHYS_N) ra_data = cells[ra_phys];
    if (int'(rb_phys) < PHYS_N) rb_data = cells[rb_phys];
  end

  assign pc_data = cells[PC_IDX];
endmodule

// File: rtl/bank_rf_top.sv
module bank_rf_top
  import bank_rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        mode_i,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              lnk_en,
  input  logic [4:0]        lnk_mode,
  input  logic [DATA_W-1:0] lnk_data,
  output logic [DATA_W-1:0] pc_o
);
  logic [PHYS_W-1:0] rd_a_phys;
  logic [PHYS_W-1:0] rd_b_phys;
  logic [PHYS_W-1:0] wr_phys;
  logic [PHYS_W-1:0] lk_phys;
  logic              wr_collide;

  bank_rf_decode u_dec_ra (.mode(mode_i),   .idx(rd_a_idx),            .phys(rd_a_phys));
  bank_rf_decode u_dec_rb (.mode(mode_i),   .idx(rd_b_idx),            .phys(rd_b_phys));
  bank_rf_decode u_dec_wr (.mode(mode_i),   .idx(wr_idx),              .phys(wr_phys));
  bank_rf_decode u_dec_lk (.mode(lnk_mode), .idx(ARCH_W'(LR_IDX)),     .phys(lk_phys));

  assign wr_collide = wr_en && lnk_en && (wr_phys == lk_phys);

  bank_rf_store #(.DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_a    (wr_en),
    .wa_phys (wr_phys),
    .wa_data (wr_data),
    .we_l    (lnk_en),
    .wl_phys (lk_phys),
    .wl_data (lnk_data),
    .ra_phys (rd_a_phys),
    .ra_data (rd_a_data),
    .rb_phys (rd_b_phys),
    .rb_data (rd_b_data),
    .pc_data (pc_o)
  );
endmodule

// File: rtl/bank_rf_chk.sv
module bank_rf_chk
  import bank_rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4:0]        mode_i,
  input logic [3:0]        rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic              wr_en,
  input logic [3:0]        wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              lnk_en,
  input logic [DATA_W-1:0] pc_o,
  input logic [PHYS_W-1:0] rd_a_phys,
  input logic              wr_collide
);
  // R5
  pc_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == 4'd15) |-> (rd_a_data == pc_o && rd_a_phys == PHYS_W'(PC_IDX)));

  // R3
  fiq_private_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 5'b10001 && rd_a_idx >= 4'd8 && rd_a_idx <= 4'd14)
      |-> (rd_a_phys >= PHYS_W'(FIQ_BASE) && rd_a_phys < PHYS_W'(EXC_BASE)));

  // R4
  low_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx < 4'd8) |-> (rd_a_phys == PHYS_W'(rd_a_idx)));

  // R7
  wr_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_collide) |=>
      ((mode_i == $past(mode_i) && rd_a_idx == $past(wr_idx))
        -> rd_a_data == $past(wr_data)));

  // R5
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !lnk_en) |=> $stable(pc_o));
endmodule

bind bank_rf_top bank_rf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .rd_a_idx(rd_a_idx),
  .rd_a_data(rd_a_data), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .lnk_en(lnk_en), .pc_o(pc_o), .rd_a_phys(rd_a_phys), .wr_collide(wr_collide)
);

// File: tb/bank_rf_tb.sv
module bank_rf_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [4:0]  mode_i = 5'b10000;
  logic [3:0]  rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = 0, lnk_data = 0, pc_o;
  logic        wr_en = 0, lnk_en = 0;
  logic [4:0]  lnk_mode = 5'b10000;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // reference storage: common view, fast-interrupt high set, per exception SP/LR
  logic [31:0] m_com [16];
  logic [31:0] m_fast [7];
  logic [31:0] m_sp [4];
  logic [31:0] m_lr [4];

  bank_rf_top dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .lnk_en(lnk_en), .lnk_mode(lnk_mode), .lnk_data(lnk_data),
    .pc_o(pc_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // -1 common, 0 fast, 1..4 irq/svc/abt/und
  function automatic int grp(input logic [4:0] m);
    if (m == 5'b10001) return 0;
    if (m == 5'b10010) return 1;
    if (m == 5'b10011) return 2;
    if (m == 5'b10111) return 3;
    if (m == 5'b11011) return 4;
    return -1;
  endfunction

  function automatic logic [31:0] ref_rd(input logic [4:0] m, input int i);
    int g = grp(m);
    if (g == 0 && i >= 8 && i <= 14) return m_fast[i-8];
    if (g > 0 && i == 13) return m_sp[g-1];
    if (g > 0 && i == 14) return m_lr[g-1];
    return m_com[i];
  endfunction

  task automatic ref_wr(input logic [4:0] m, input int i, input logic [31:0] v);
    int g = grp(m);
    if (g == 0 && i >= 8 && i <= 14) m_fast[i-8] = v;
    else if (g > 0 && i == 13) m_sp[g-1] = v;
    else if (g > 0 && i == 14) m_lr[g-1] = v;
    else m_com[i] = v;
  endtask

  task automatic cmp(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic [4:0] m,
                      input logic [3:0] ra, input logic [3:0] rb,
                      input logic we, input logic [3:0] wi, input logic [31:0] wd,
                      input logic le, input logic [4:0] lm, input logic [31:0] ld);
    mode_i = m; rd_a_idx = ra; rd_b_idx = rb;
    wr_en = we; wr_idx = wi; wr_data = wd;
    lnk_en = le; lnk_mode = lm; lnk_data = ld;
    #1;
    cmp(tag, "port A", rd_a_data, ref_rd(m, int'(ra)));
    cmp(tag, "port B", rd_b_data, ref_rd(m, int'(rb)));
    cmp(tag, "pc", pc_o, m_com[15]);
    @(posedge clk);
    if (rst_n) begin
      if (we) ref_wr(m, int'(wi), wd);
      if (le) ref_wr(lm, 14, ld);
    end
    @(negedge clk);
  endtask

  task automatic rd(input string tag, input logic [4:0] m,
                    input logic [3:0] ra, input logic [3:0] rb);
    step(tag, m, ra, rb, 0, 0, 0, 0, 5'b10000, 0);
  endtask

  localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                         SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011,
                         SYS = 5'b11111, BAD = 5'b00101;

  initial begin
    logic [4:0] modes [8];
    modes = '{USR, FIQ, IRQ, SVC, ABT, UND, SYS, BAD};
    for (int i = 0; i < 16; i++) m_com[i] = 0;
    for (int i = 0; i < 7; i++) m_fast[i] = 0;
    for (int i = 0; i < 4; i++) begin m_sp[i] = 0; m_lr[i] = 0; end

    // R1: zero during reset in every mode (writes attempted are dropped)
    @(negedge clk);
    for (int k = 0; k < 8; k++)
      for (int i = 0; i < 16; i += 2)
        step("R1", modes[k], 4'(i), 4'(i+1), 1, 4'(i), 32'hFFFF_FFFF, 1, modes[k], 32'h1);
    rst_n = 1;
    for (int k = 0; k < 8; k++) rd("R1", modes[k], 4'd13, 4'd14);

    // R7 / R2: write in user, seen in system and in unlisted code
    step("R7", USR, 5, 9, 1, 5, 32'hA5A5_0005, 0, USR, 0);
    step("R2", SYS, 5, 9, 1, 9, 32'h0000_0909, 0, USR, 0);
    rd("R2", BAD, 5, 9);
    rd("R2", USR, 9, 5);
    // R6: same-cycle read returns old value, next cycle returns new
    step("R6", USR, 5, 5, 1, 5, 32'h1234_5678, 0, USR, 0);
    rd("R6", USR, 5, 5);

    // R3: fast-interrupt high set private, low set shared
    for (int i = 8; i <= 14; i++) step("R3", FIQ, 4'(i), 4'(i), 1, 4'(i), 32'hF100_0000 + i, 0, USR, 0);
    step("R3", FIQ, 7, 8, 1, 7, 32'h7777_0007, 0, USR, 0);
    for (int i = 7; i <= 14; i++) rd("R3", USR, 4'(i), 4'(i));
    for (int i = 7; i <= 14; i++) rd("R3", FIQ, 4'(i), 4'(i));

    // R4: each exception mode has its own SP/LR, shares R12
    step("R4", IRQ, 13, 14, 1, 13, 32'h5151_0013, 0, USR, 0);
    step("R4", IRQ, 13, 14, 1, 14, 32'h5151_0014, 0, USR, 0);
    step("R4", SVC, 13, 14, 1, 13, 32'h5353_0013, 0, USR, 0);
    step("R4", ABT, 13, 12, 1, 12, 32'hC0C0_0012, 0, USR, 0);
    for (int k = 0; k < 8; k++) rd("R4", modes[k], 13, 14);
    rd("R4", IRQ, 12, 12);

    // R5: one PC for all modes
    step("R5", FIQ, 15, 15, 1, 15, 32'h0000_8000, 0, USR, 0);
    rd("R5", UND, 15, 15);
    step("R5", SVC, 15, 0, 1, 15, 32'h0000_8004, 0, USR, 0);
    rd("R5", USR, 15, 15);

    // R8: exception path writes another mode's R14
    step("R8", USR, 14, 0, 0, 0, 0, 1, SVC, 32'h0BAD_0014);
    rd("R8", SVC, 14, 13);
    rd("R8", USR, 14, 14);
    step("R8", IRQ, 14, 0, 0, 0, 0, 1, BAD, 32'hCAFE_0014);
    rd("R8", USR, 14, 14);

    // R9: both paths to the same register, link wins
    step("R9", UND, 14, 14, 1, 14, 32'h1111_1111, 1, UND, 32'h2222_2222);
    rd("R9", UND, 14, 14);
    step("R9", SYS, 14, 14, 1, 14, 32'h3333_3333, 1, BAD, 32'h4444_4444);
    rd("R9", USR, 14, 14);

    // R6 / R7: mixed random traffic
    for (int n = 0; n < 3000; n++)
      step("R6", modes[$urandom_range(7)], 4'($urandom), 4'($urandom),
           1'($urandom), 4'($urandom), $urandom,
           ($urandom_range(3) == 0), modes[$urandom_range(7)], $urandom);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule